// File: doc/BRIEF.md
# Home-Node Coherence Sequencer with Speculative Memory Read

This block sits at the home of a range of block addresses and puts the coherence requests for those blocks into one order. A request arrives on a ready/valid port as a plain read, a read-for-ownership or an ownership upgrade. A small direct-mapped filter records which blocks are cached and, for blocks held exclusively, which node holds them. The sequencer handles one request at a time. A read starts a memory read in the cycle after acceptance, without waiting for the filter result. The filter result is read in that same cycle and decides the outcome. If no node owns the block, the sequencer replies with the memory data. If a node owns the block, the request is forwarded to that node and the speculative memory data is thrown away.

Reads to a block may overlap, and their completion notices can arrive in any order. The sequencer keeps a single counter of read completions still expected. Ownership requests are held back until that counter is zero. Only one ownership transaction is open at a time. It closes when the requester sends a write completion notice, and at that point the filter records the requester as exclusive owner. While that transaction is open, requests to the same address are held off by deasserting the request ready.

Top module: `cohSeq`

## Requirements
- R1: A read request (kind 0, or kind 3, which is treated as a read) accepted in cycle N raises the memory request valid in cycle N+1, with the memory address equal to the request address. This happens whatever the filter holds.
- R2: For a read or read-for-ownership whose block is not exclusively owned, the reply valid stays low until the memory response is taken. The reply is raised in the cycle after that handshake and carries the memory data, with the destination equal to the requester.
- R3: For a read whose block is owned (filter state exclusive=2 or modified=3 with a matching tag), the request is forwarded. The forward destination is the owner, the source is the requester and the kind is the request kind. The memory response is then consumed and no reply is sent.
- R4: A read-for-ownership (kind 1) or upgrade (kind 2) is not accepted while any read completion is outstanding. It is accepted once completion notices have arrived for all accepted reads, in any order.
- R5: The outstanding-read counter stops at MAX_READS. A read offered while the counter is at that value is held off.
- R6: While an ownership transaction is open, any request to its address is held off, and so is any other ownership request. Reads to other addresses are accepted.
- R7: A write completion notice (done valid with done-write high) closes the open ownership transaction. It sets the filter entry at index addr[IDX_W-1:0] to exclusive, with the requester as owner.
- R8: An ownership request to an owned block is forwarded to the owner with no memory read. An upgrade to a block that is not owned gets a reply with zero data and no memory read.
- R9: After a read has been served, by memory or by forwarding, the filter entry becomes shared. The next read to that block is served from memory.
- R10: After reset the filter is empty, no read is outstanding, no ownership transaction is open, and the memory, forward and reply valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted when high with valid |
| reqKind | input | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 read |
| reqAddr | input | ADDR_W | Block address |
| reqSrc | input | NODE_W | Requesting node |
| memReqValid | output | 1 | Memory read valid |
| memReqReady | input | 1 | Memory read accepted |
| memReqAddr | output | ADDR_W | Memory read address |
| memRspValid | input | 1 | Memory data valid |
| memRspReady | output | 1 | Memory data taken |
| memRspData | input | DATA_W | Memory data |
| fwdValid | output | 1 | Forward to owner valid |
| fwdReady | input | 1 | Forward accepted |
| fwdDst | output | NODE_W | Owner node |
| fwdSrc | output | NODE_W | Original requester |
| fwdKind | output | 2 | Request kind being forwarded |
| fwdAddr | output | ADDR_W | Block address |
| rplValid | output | 1 | Reply to requester valid |
| rplReady | input | 1 | Reply accepted |
| rplDst | output | NODE_W | Requester node |
| rplData | output | DATA_W | Block data (zero for an upgrade grant) |
| doneValid | input | 1 | Completion notice |
| doneWrite | input | 1 | Notice closes the ownership transaction when high, a read otherwise |

## Verification
The bench targets the cases where speculation and ordering meet. The first is a read to an owned block. Here the memory data comes back after the forward has gone out. A design that did not drop that data would send the requester a stale second reply. The second is an ownership request offered while reads are still open, with their notices returned in a shuffled order. Accepting it early, or losing count of the notices, shows up as reqReady going high too soon or never. The bench also tries a read at the counter limit, and a read to the address of an open ownership transaction, where a missing stall would let the read through ahead of the write. Finally it aliases addresses onto one filter index. A tag check that was missing or wrong would forward a read to a node that does not hold the block.

// File: rtl/cohSeqPkg.sv
`timescale 1ns/1ps
package cohSeqPkg;

  localparam logic [1:0] K_RD     = 2'd0;
  localparam logic [1:0] K_RDOWN  = 2'd1;
  localparam logic [1:0] K_UPG    = 2'd2;
  localparam logic [1:0] K_RD_ALT = 2'd3;

  localparam logic [1:0] FS_INV = 2'd0;
  localparam logic [1:0] FS_SHR = 2'd1;
  localparam logic [1:0] FS_EXC = 2'd2;
  localparam logic [1:0] FS_MOD = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_FWD,
    ST_DRAIN,
    ST_WAIT,
    ST_REPLY
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic bumpRead;
    logic openWrite;
    logic snapLook;
    logic grabMem;
    logic markShared;
  } ctrlStrobe_t;

  function automatic logic kindIsRead(input logic [1:0] k);
    return (k == K_RD) || (k == K_RD_ALT);
  endfunction

endpackage

// File: rtl/cohSeqData.sv
`timescale 1ns/1ps
module cohSeqData
  import cohSeqPkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NODE_W    = 2,
  parameter int DATA_W    = 16,
  parameter int IDX_W     = 2,
  parameter int MAX_READS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [NODE_W-1:0] reqSrc,
  input  logic [DATA_W-1:0] memRspData,
  input  logic              doneValid,
  input  logic              doneWrite,
  output logic [1:0]        curKind,
  output logic [ADDR_W-1:0] curAddr,
  output logic [NODE_W-1:0] curSrc,
  output logic [DATA_W-1:0] curData,
  output logic              lookOwned,
  output logic [NODE_W-1:0] snapOwner,
  output logic              cntFull,
  output logic              cntZero,
  output logic              writeBusy,
  output logic [ADDR_W-1:0] writeAddr
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = ADDR_W - IDX_W;
  localparam int CNT_W   = $clog2(MAX_READS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_READS);

  // request registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curKind <= K_RD;
      curAddr <= '0;
      curSrc  <= '0;
    end else if (stb.latchReq) begin
      curKind <= reqKind;
      curAddr <= reqAddr;
      curSrc  <= reqSrc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             curData <= '0;
    else if (stb.latchReq) curData <= '0;
    else if (stb.grabMem)  curData <= memRspData;
  end

  // open ownership transaction
  logic [NODE_W-1:0] writeOwner;
  logic              wrClose;
  assign wrClose = doneValid && doneWrite && writeBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      writeBusy  <= 1'b0;
      writeAddr  <= '0;
      writeOwner <= '0;
    end else if (stb.openWrite) begin
      writeBusy  <= 1'b1;
      writeAddr  <= reqAddr;
      writeOwner <= reqSrc;
    end else if (wrClose) begin
      writeBusy  <= 1'b0;
    end
  end

  // outstanding read counter
  logic [CNT_W-1:0] readCnt;
  logic             readDec;
  assign readDec = doneValid && !doneWrite && (readCnt != '0);
  assign cntFull = (readCnt == CNT_MAX);
  assign cntZero = (readCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readCnt <= '0;
    else if (stb.bumpRead && !readDec) readCnt <= readCnt + 1'b1;
    else if (!stb.bumpRead && readDec) readCnt <= readCnt - 1'b1;
  end

  // direct-mapped filter
  logic [IDX_W-1:0] cIdx, wIdx;
  logic [TAG_W-1:0] cTag, wTag;
  assign cIdx = curAddr[IDX_W-1:0];
  assign cTag = curAddr[ADDR_W-1:IDX_W];
  assign wIdx = writeAddr[IDX_W-1:0];
  assign wTag = writeAddr[ADDR_W-1:IDX_W];

  logic [ENTRIES-1:0][1:0]        stVec;
  logic [ENTRIES-1:0][TAG_W-1:0]  tagVec;
  logic [ENTRIES-1:0][NODE_W-1:0] ownVec;

  for (genvar e = 0; e < ENTRIES; e++) begin : gEnt
    logic [1:0]        stQ;
    logic [TAG_W-1:0]  tagQ;
    logic [NODE_W-1:0] ownQ;
    logic              closeHit, shareHit;
    assign closeHit = wrClose && (wIdx == IDX_W'(e));
    assign shareHit = stb.markShared && (cIdx == IDX_W'(e));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stQ  <= FS_INV;
        tagQ <= '0;
        ownQ <= '0;
      end else if (closeHit) begin
        stQ  <= FS_EXC;
        tagQ <= wTag;
        ownQ <= writeOwner;
      end else if (shareHit) begin
        stQ  <= FS_SHR;
        tagQ <= cTag;
      end
    end
    assign stVec[e]  = stQ;
    assign tagVec[e] = tagQ;
    assign ownVec[e] = ownQ;
  end

  logic lookHit;
  assign lookHit   = (stVec[cIdx] != FS_INV) && (tagVec[cIdx] == cTag);
  assign lookOwned = lookHit && ((stVec[cIdx] == FS_EXC) || (stVec[cIdx] == FS_MOD));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             snapOwner <= '0;
    else if (stb.snapLook) snapOwner <= ownVec[cIdx];
  end

endmodule

// File: rtl/cohSeqCtrl.sv
`timescale 1ns/1ps
module cohSeqCtrl
  import cohSeqPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        curKind,
  input  logic              lookOwned,
  input  logic              cntFull,
  input  logic              cntZero,
  input  logic              writeBusy,
  input  logic [ADDR_W-1:0] writeAddr,
  input  logic              memReqReady,
  input  logic              memRspValid,
  input  logic              fwdReady,
  input  logic              rplReady,
  output ctrlStrobe_t       stb,
  output logic              reqReady,
  output logic              memReqValid,
  output logic              memRspReady,
  output logic              fwdValid,
  output logic              rplValid
);

  seqState_t state, stateNext;

  logic inIsRead, curIsRead, addrBlocked, needFetch, accept;

  assign inIsRead    = kindIsRead(reqKind);
  assign curIsRead   = kindIsRead(curKind);
  assign addrBlocked = writeBusy && (reqAddr == writeAddr);
  assign needFetch   = curIsRead || ((curKind == K_RDOWN) && !lookOwned);

  assign reqReady = (state == ST_IDLE) && !addrBlocked &&
                    (inIsRead ? !cntFull : (cntZero && !writeBusy));
  assign accept   = reqValid && reqReady;

  always_comb begin
    stateNext   = state;
    stb         = '0;
    memReqValid = 1'b0;
    memRspReady = 1'b0;
    fwdValid    = 1'b0;
    rplValid    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          stb.latchReq  = 1'b1;
          stb.bumpRead  = inIsRead;
          stb.openWrite = !inIsRead;
          stateNext     = ST_LAUNCH;
        end
      end
      ST_LAUNCH: begin
        memReqValid  = needFetch;
        stb.snapLook = 1'b1;
        if (!needFetch || memReqReady) begin
          if (lookOwned)             stateNext = ST_FWD;
          else if (curKind == K_UPG) stateNext = ST_REPLY;
          else                       stateNext = ST_WAIT;
        end
      end
      ST_FWD: begin
        fwdValid = 1'b1;
        if (fwdReady) begin
          stb.markShared = curIsRead;
          stateNext      = curIsRead ? ST_DRAIN : ST_IDLE;
        end
      end
      ST_DRAIN: begin
        memRspReady = 1'b1;
        if (memRspValid) stateNext = ST_IDLE;
      end
      ST_WAIT: begin
        memRspReady = 1'b1;
        if (memRspValid) begin
          stb.grabMem = 1'b1;
          stateNext   = ST_REPLY;
        end
      end
      ST_REPLY: begin
        rplValid = 1'b1;
        if (rplReady) begin
          stb.markShared = curIsRead;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/cohSeq.sv
`timescale 1ns/1ps
module cohSeq
  import cohSeqPkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NODE_W    = 2,
  parameter int DATA_W    = 16,
  parameter int IDX_W     = 2,
  parameter int MAX_READS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [NODE_W-1:0] reqSrc,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  output logic              memRspReady,
  input  logic [DATA_W-1:0] memRspData,
  output logic              fwdValid,
  input  logic              fwdReady,
  output logic [NODE_W-1:0] fwdDst,
  output logic [NODE_W-1:0] fwdSrc,
  output logic [1:0]        fwdKind,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic              rplValid,
  input  logic              rplReady,
  output logic [NODE_W-1:0] rplDst,
  output logic [DATA_W-1:0] rplData,
  input  logic              doneValid,
  input  logic              doneWrite
);

  ctrlStrobe_t       stb;
  logic [1:0]        curKind;
  logic [ADDR_W-1:0] curAddr, writeAddr;
  logic [NODE_W-1:0] curSrc, snapOwner;
  logic [DATA_W-1:0] curData;
  logic              lookOwned, cntFull, cntZero, writeBusy;

  cohSeqCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqKind(reqKind), .reqAddr(reqAddr),
    .curKind(curKind), .lookOwned(lookOwned),
    .cntFull(cntFull), .cntZero(cntZero),
    .writeBusy(writeBusy), .writeAddr(writeAddr),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .fwdReady(fwdReady), .rplReady(rplReady),
    .stb(stb), .reqReady(reqReady),
    .memReqValid(memReqValid), .memRspReady(memRspReady),
    .fwdValid(fwdValid), .rplValid(rplValid)
  );

  cohSeqData #(
    .ADDR_W(ADDR_W), .NODE_W(NODE_W), .DATA_W(DATA_W),
    .IDX_W(IDX_W), .MAX_READS(MAX_READS)
  ) u_data (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqKind(reqKind), .reqAddr(reqAddr), .reqSrc(reqSrc),
    .memRspData(memRspData),
    .doneValid(doneValid), .doneWrite(doneWrite),
    .curKind(curKind), .curAddr(curAddr), .curSrc(curSrc),
    .curData(curData), .lookOwned(lookOwned), .snapOwner(snapOwner),
    .cntFull(cntFull), .cntZero(cntZero),
    .writeBusy(writeBusy), .writeAddr(writeAddr)
  );

  assign memReqAddr = curAddr;
  assign fwdDst     = snapOwner;
  assign fwdSrc     = curSrc;
  assign fwdKind    = curKind;
  assign fwdAddr    = curAddr;
  assign rplDst     = curSrc;
  assign rplData    = curData;

endmodule

// File: rtl/cohSeqChk.sv
`timescale 1ns/1ps
module cohSeqChk #(
  parameter int ADDR_W    = 8,
  parameter int NODE_W    = 2,
  parameter int DATA_W    = 16,
  parameter int MAX_READS = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [1:0]        reqKind,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              memReqValid,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic              memRspReady,
  input logic              fwdValid,
  input logic              rplValid,
  input logic              rplReady,
  input logic [DATA_W-1:0] rplData,
  input logic              doneValid,
  input logic              doneWrite
);

  logic accRead, accWrite;
  assign accRead  = reqValid && reqReady && (reqKind == 2'd0 || reqKind == 2'd3);
  assign accWrite = reqValid && reqReady && (reqKind == 2'd1 || reqKind == 2'd2);

  // observer of outstanding reads and the open ownership transaction
  logic [7:0]        obsCnt;
  logic              obsBusy;
  logic [ADDR_W-1:0] obsAddr;
  logic              obsDec;
  assign obsDec = doneValid && !doneWrite && (obsCnt != 8'd0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) obsCnt <= 8'd0;
    else obsCnt <= obsCnt + {7'd0, accRead} - {7'd0, obsDec};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      obsBusy <= 1'b0;
      obsAddr <= '0;
    end else if (accWrite) begin
      obsBusy <= 1'b1;
      obsAddr <= reqAddr;
    end else if (doneValid && doneWrite) begin
      obsBusy <= 1'b0;
    end
  end

  assert_spec_fetch_R1: assert property (@(posedge clk) disable iff (!rstN)
    accRead |=> memReqValid && (memReqAddr == $past(reqAddr)));

  assert_reply_after_mem_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rplValid) && (rplData != '0)) |-> $past(memRspValid && memRspReady));

  assert_fwd_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> (!rplValid && !memReqValid));

  assert_write_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    accWrite |-> (obsCnt == 8'd0));

  assert_read_cap_R5: assert property (@(posedge clk) disable iff (!rstN)
    accRead |-> (obsCnt < 8'(MAX_READS)));

  assert_block_open_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |-> !(obsBusy && (reqAddr == obsAddr)));

  assert_reply_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rplValid && !rplReady) |=> (rplValid && $stable(rplData)));

endmodule

bind cohSeq cohSeqChk #(
  .ADDR_W(ADDR_W), .NODE_W(NODE_W), .DATA_W(DATA_W), .MAX_READS(MAX_READS)
) u_chk (
  .clk(clk), .rstN(rstN),
  .reqValid(reqValid), .reqReady(reqReady), .reqKind(reqKind), .reqAddr(reqAddr),
  .memReqValid(memReqValid), .memReqAddr(memReqAddr),
  .memRspValid(memRspValid), .memRspReady(memRspReady),
  .fwdValid(fwdValid), .rplValid(rplValid), .rplReady(rplReady), .rplData(rplData),
  .doneValid(doneValid), .doneWrite(doneWrite)
);

// File: tb/cohSeq_bench.sv
`timescale 1ns/1ps
module cohSeq_bench;

  localparam int ADDR_W = 8, NODE_W = 2, DATA_W = 16, IDX_W = 2, MAX_READS = 3;

  logic clk = 1'b0, rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic              reqValid = 0, reqReady;
  logic [1:0]        reqKind = 0;
  logic [ADDR_W-1:0] reqAddr = 0;
  logic [NODE_W-1:0] reqSrc = 0;
  logic              memReqValid, memReqReady = 1;
  logic [ADDR_W-1:0] memReqAddr;
  logic              memRspValid = 0, memRspReady;
  logic [DATA_W-1:0] memRspData = 0;
  logic              fwdValid, fwdReady = 1;
  logic [NODE_W-1:0] fwdDst, fwdSrc;
  logic [1:0]        fwdKind;
  logic [ADDR_W-1:0] fwdAddr;
  logic              rplValid, rplReady = 1;
  logic [NODE_W-1:0] rplDst;
  logic [DATA_W-1:0] rplData;
  logic              doneValid = 0, doneWrite = 0;

  cohSeq #(.ADDR_W(ADDR_W), .NODE_W(NODE_W), .DATA_W(DATA_W),
           .IDX_W(IDX_W), .MAX_READS(MAX_READS)) u_cohSeq (.*);

  int nChecks = 0, nBad = 0;

  // bench model of the filter, indexed by addr[1:0]
  logic [1:0]        mSt  [4];
  logic [5:0]        mTag [4];
  logic [NODE_W-1:0] mOwn [4];
  int                nOut = 0;
  logic              wPend = 0;
  logic [ADDR_W-1:0] pAddr = 0;
  logic [NODE_W-1:0] pSrc = 0;

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic isRd(input logic [1:0] k);
    return (k == 2'd0) || (k == 2'd3);
  endfunction

  function automatic logic owned(input logic [ADDR_W-1:0] a);
    return (mSt[a[1:0]] >= 2'd2) && (mTag[a[1:0]] == a[7:2]);
  endfunction

  function automatic logic expFetch(input logic [1:0] k, input logic own);
    return isRd(k) || (k == 2'd1 && !own);
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic sendReq(input logic [1:0] k, input logic [ADDR_W-1:0] a,
                         input logic [NODE_W-1:0] s, output int waits);
    reqValid = 1; reqKind = k; reqAddr = a; reqSrc = s; waits = 0;
    forever begin
      @(negedge clk);
      if (reqReady || waits > 40) break;
      waits++;
    end
    step();
    reqValid = 0;
  endtask

  task automatic expectStall(input logic [1:0] k, input logic [ADDR_W-1:0] a,
                             input logic [NODE_W-1:0] s, input string req);
    reqValid = 1; reqKind = k; reqAddr = a; reqSrc = s;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(reqReady == 1'b0, req, "stall reqReady", int'(reqReady), 0);
    end
    reqValid = 0;
    step();
  endtask

  task automatic sendDone(input logic w);
    doneValid = 1; doneWrite = w;
    step();
    doneValid = 0; doneWrite = 0;
    if (w && wPend) begin
      mSt[pAddr[1:0]] = 2'd2; mTag[pAddr[1:0]] = pAddr[7:2]; mOwn[pAddr[1:0]] = pSrc;
      wPend = 0;
    end else if (!w && nOut > 0) nOut--;
  endtask

  task automatic runTxn(input logic [1:0] k, input logic [ADDR_W-1:0] a,
                        input logic [NODE_W-1:0] s);
    logic own, fetch;
    logic [NODE_W-1:0] expOwn;
    logic [DATA_W-1:0] d;
    int waits, lat;
    own = owned(a); fetch = expFetch(k, own); expOwn = mOwn[a[1:0]];
    sendReq(k, a, s, waits);
    check(waits == 0, "R4 R5 R6", "accept delay", waits, 0);
    @(negedge clk);
    check(memReqValid == fetch, "R1", "memReqValid", int'(memReqValid), int'(fetch));
    if (fetch) check(memReqAddr == a, "R1", "memReqAddr", int'(memReqAddr), int'(a));
    step();
    if (own) begin
      @(negedge clk);
      check(fwdValid == 1'b1, "R3", "fwdValid", int'(fwdValid), 1);
      check(fwdDst == expOwn, "R7", "fwdDst", int'(fwdDst), int'(expOwn));
      check(fwdSrc == s && fwdKind == k && fwdAddr == a, "R8", "fwd fields",
            int'({fwdSrc, fwdKind}), int'({s, k}));
      step();
      if (isRd(k)) begin
        memRspValid = 1; memRspData = 16'hDEAD;
        step();
        memRspValid = 0;
        for (int i = 0; i < 3; i++) begin
          @(negedge clk);
          check(rplValid == 1'b0, "R3", "dropped mem data replied", int'(rplValid), 0);
        end
        step();
      end
    end else if (k == 2'd2) begin
      @(negedge clk);
      check(rplValid && rplData == '0 && rplDst == s, "R8", "upgrade grant",
            int'(rplData), 0);
      step();
    end else begin
      lat = int'($urandom % 4);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        check(rplValid == 1'b0, "R2", "early reply", int'(rplValid), 0);
        step();
      end
      d = DATA_W'($urandom) | 16'h1;
      memRspValid = 1; memRspData = d;
      step();
      memRspValid = 0;
      @(negedge clk);
      check(rplValid == 1'b1, "R2", "rplValid", int'(rplValid), 1);
      check(rplData == d, "R2", "rplData", int'(rplData), int'(d));
      check(rplDst == s, "R2", "rplDst", int'(rplDst), int'(s));
      step();
    end
    if (isRd(k)) begin
      mSt[a[1:0]] = 2'd1; mTag[a[1:0]] = a[7:2]; // R9
      nOut++;
    end else begin
      wPend = 1; pAddr = a; pSrc = s;
    end
  endtask

  initial begin
    #500000;
    nChecks++; nBad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] pool [6];
    logic [1:0] k;
    logic [ADDR_W-1:0] a;
    logic [NODE_W-1:0] s;
    void'($urandom(32'd1234));
    pool[0] = 8'h10; pool[1] = 8'h11; pool[2] = 8'h21;
    pool[3] = 8'h30; pool[4] = 8'h50; pool[5] = 8'h90;
    for (int i = 0; i < 4; i++) begin mSt[i] = 0; mTag[i] = 0; mOwn[i] = 0; end
    repeat (3) step();
    rstN = 1;
    @(negedge clk);
    check(!memReqValid && !fwdValid && !rplValid, "R10", "valids after reset",
          int'({memReqValid, fwdValid, rplValid}), 0);
    check(reqReady == 1'b1, "R10", "reqReady after reset", int'(reqReady), 1);
    step();

    runTxn(2'd0, 8'h10, 2'd1);                   // R1 R2 uncached read
    expectStall(2'd1, 8'h10, 2'd2, "R4");        // read outstanding
    sendDone(0);
    runTxn(2'd1, 8'h10, 2'd2);                   // readEx from memory
    expectStall(2'd0, 8'h10, 2'd3, "R6");        // same address
    expectStall(2'd2, 8'h22, 2'd3, "R6");        // second write
    runTxn(2'd0, 8'h21, 2'd3);                   // R6 other address accepted
    sendDone(0);
    sendDone(1);                                 // R7
    runTxn(2'd0, 8'h10, 2'd1);                   // R3 R7 forward to node 2
    runTxn(2'd3, 8'h10, 2'd3);                   // R9 shared now
    runTxn(2'd0, 8'h11, 2'd0);                   // count reaches 3
    expectStall(2'd0, 8'h21, 2'd1, "R5");
    sendDone(0);
    runTxn(2'd0, 8'h21, 2'd1);
    repeat (3) sendDone(0);
    runTxn(2'd2, 8'h30, 2'd0);                   // R8 upgrade grant
    sendDone(1);
    runTxn(2'd1, 8'h30, 2'd1);                   // R8 forward, no fetch
    sendDone(1);
    runTxn(2'd0, 8'h30, 2'd2);                   // R7 owner now node 1
    sendDone(0);

    for (int it = 0; it < 300; it++) begin
      k = 2'($urandom); a = pool[$urandom % 6]; s = NODE_W'($urandom);
      if (!isRd(k)) begin
        if (wPend) begin expectStall(k, a, s, "R6"); sendDone(1); end
        if (nOut > 0) begin
          expectStall(k, a, s, "R4");
          while (nOut > 0) sendDone(0);
        end
      end else begin
        if (wPend && a == pAddr) begin expectStall(k, a, s, "R6"); sendDone(1); end
        if (nOut >= MAX_READS) begin expectStall(k, a, s, "R5"); sendDone(0); end
      end
      runTxn(k, a, s);
      if ($urandom % 3 == 0 && nOut > 0) sendDone(0);
      if ($urandom % 4 == 0 && wPend) sendDone(1);
    end

    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule